// File: doc/BRIEF.md
# S/PDIF Subframe Parity Guard with Error Concealment

This block sits after a biphase-mark decoder on a one-way digital audio link. For each decoded 32-bit subframe, offered with a one-cycle strobe and a decoded sync type, it separates the audio, flag and sync fields and recomputes even parity. The link has no return path, so a parity failure cannot be repaired or requested again. The block can only decide what to present in place of the damaged sample.

A runtime mode input selects one of three policies for a failed subframe. Mute outputs zero. Hold repeats the last sample that passed parity on the same channel. Pass forwards the damaged value unchanged. Samples are signed two's-complement values, so one flipped top bit turns a quiet positive sample into a full-scale negative one; the policy decides whether that spike reaches the converter. A saturating counter records how many subframes failed, and a synchronous clear input resets it.

Top module: `spdif_frame_guard`

## Requirements
- R1: Subframe layout: bits [3:0] hold the sync field, bits [27:4] the 24-bit audio sample (least significant bit at bit 4, top bit at bit 27), and bits [31:28] the flag field, with bit 31 as the parity bit.
- R2: Parity is even over bits [31:4]. A subframe with an even number of ones there is good, and its audio field is output unchanged in every mode.
- R3: `sample_vld_o` is high exactly one clock after each cycle in which `word_vld_i` is high, whether the subframe is good or not, and low otherwise. The other outputs change only with it.
- R4: `chan_right_o` is 1 when `sync_kind_i` was 2'b10 (right-channel sync) and 0 for the codes 2'b00, 2'b01 and 2'b11 (left channel).
- R5: When `conceal_mode_i` is 2'b00 or 2'b11 (mute), a failed subframe produces a sample of zero.
- R6: When `conceal_mode_i` is 2'b01 (hold), a failed subframe produces the last good sample received on the same channel. Left and right are kept apart, and each held value is zero after reset.
- R7: When `conceal_mode_i` is 2'b10 (pass), a failed subframe produces its received audio field unchanged.
- R8: `err_cnt_o` increases by one for each failed subframe and stops at 65535.
- R9: `err_clr_i` sets `err_cnt_o` to zero on the next clock and overrides an increment in the same cycle.
- R10: `flags_o` carries the received bits [31:28] unchanged, including for failed subframes.
- R11: After reset all outputs are zero.
- R12: The sync field bits [3:0] affect neither the parity result nor the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_i | input | 32 | Decoded subframe |
| sync_kind_i | input | 2 | Decoded sync type; 2'b10 means right channel |
| word_vld_i | input | 1 | Subframe strobe |
| conceal_mode_i | input | 2 | Concealment policy: 00/11 mute, 01 hold, 10 pass |
| err_clr_i | input | 1 | Synchronous clear of the error counter |
| sample_o | output | 24 | Presented audio sample |
| chan_right_o | output | 1 | 1 for right channel, 0 for left |
| flags_o | output | 4 | Received flag field |
| sample_vld_o | output | 1 | Output strobe, one clock after the input strobe |
| err_cnt_o | output | 16 | Saturating count of failed subframes |

## Verification
Good subframes use random audio and sync bits, which shows that the sync nibble is left out of the parity and that the audio field sits in the right place. Damaged subframes flip the top audio bit of a small positive sample. The three policies then give three distinct results: zero, the held value, or a large negative value. Hold is tried with left and right subframes interleaved and with no good sample received yet, which shows whether the two channels are kept apart and whether the held value resets to zero. A long burst of damaged subframes drives the counter into saturation, and a clear arriving together with a failure shows that the clear wins.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

  typedef enum logic [1:0] {
    CONCEAL_MUTE     = 2'b00,
    CONCEAL_HOLD     = 2'b01,
    CONCEAL_PASS     = 2'b10,
    CONCEAL_MUTE_ALT = 2'b11
  } conceal_e;

  localparam logic [1:0] SYNC_RIGHT = 2'b10;

  // Channel index from the decoded sync type (R4): 1 = right, 0 = left.
  function automatic logic sync_is_right(input logic [1:0] kind);
    return (kind == SYNC_RIGHT);
  endfunction

endpackage

// File: rtl/sf_field_split.sv
module sf_field_split #(
  parameter int WORD_W  = 32,
  parameter int SYNC_W  = 4,
  parameter int AUDIO_W = 24,
  parameter int FLAG_W  = 4
) (
  input  logic [WORD_W-1:0]  word_i,
  output logic [AUDIO_W-1:0] audio_o,
  output logic [FLAG_W-1:0]  flags_o,
  output logic               parity_bad_o
);
  localparam int AUD_LO = SYNC_W;
  localparam int AUD_HI = SYNC_W + AUDIO_W - 1;
  localparam int FLG_LO = AUD_HI + 1;
  localparam logic [WORD_W-1:0] CHECK_MASK = {{(WORD_W-SYNC_W){1'b1}}, {SYNC_W{1'b0}}};

  assign audio_o      = word_i[AUD_HI:AUD_LO];
  assign flags_o      = word_i[WORD_W-1:FLG_LO];
  // Even parity over everything but the sync field (R2, R12).
  assign parity_bad_o = ^(word_i & CHECK_MASK);
endmodule

// File: rtl/sf_hold_bank.sv
module sf_hold_bank #(
  parameter int AUDIO_W = 24,
  parameter int CH_N    = 2,
  localparam int CH_W   = (CH_N > 1) ? $clog2(CH_N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CH_W-1:0]    wr_ch,
  input  logic [AUDIO_W-1:0] wr_data,
  input  logic [CH_W-1:0]    rd_ch,
  output logic [AUDIO_W-1:0] rd_data
);
  logic [AUDIO_W-1:0] held_q [CH_N];

  for (genvar g = 0; g < CH_N; g++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            held_q[g] <= '0;
      else if (wr_en && (int'(wr_ch) == g)) held_q[g] <= wr_data;
    end
  end

  assign rd_data = held_q[rd_ch];
endmodule

// File: rtl/sf_err_tally.sv
module sf_err_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bump,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (clr)                       cnt <= '0;
    else if (bump && (cnt != CNT_MAX))  cnt <= cnt + CNT_ONE;
  end
endmodule

// File: rtl/spdif_frame_guard.sv
module spdif_frame_guard #(
  parameter int WORD_W  = 32,
  parameter int SYNC_W  = 4,
  parameter int AUDIO_W = 24,
  parameter int FLAG_W  = 4,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WORD_W-1:0]  word_i,
  input  logic [1:0]         sync_kind_i,
  input  logic               word_vld_i,
  input  logic [1:0]         conceal_mode_i,
  input  logic               err_clr_i,
  output logic [AUDIO_W-1:0] sample_o,
  output logic               chan_right_o,
  output logic [FLAG_W-1:0]  flags_o,
  output logic               sample_vld_o,
  output logic [CNT_W-1:0]   err_cnt_o
);
  import sfg_pkg::*;

  localparam int CH_N = 2;
  localparam int CH_W = 1;

  logic [AUDIO_W-1:0] audio_w;
  logic [FLAG_W-1:0]  flags_w;
  logic               parity_bad_w;
  logic [CH_W-1:0]    chan_w;
  logic               good_accept_w;
  logic               bad_accept_w;
  logic [AUDIO_W-1:0] held_w;
  logic [AUDIO_W-1:0] next_sample_w;
  conceal_e           mode_w;

  sf_field_split #(
    .WORD_W(WORD_W), .SYNC_W(SYNC_W), .AUDIO_W(AUDIO_W), .FLAG_W(FLAG_W)
  ) u_split (
    .word_i      (word_i),
    .audio_o     (audio_w),
    .flags_o     (flags_w),
    .parity_bad_o(parity_bad_w)
  );

  assign chan_w        = sync_is_right(sync_kind_i);
  assign good_accept_w = word_vld_i && !parity_bad_w;
  assign bad_accept_w  = word_vld_i &&  parity_bad_w;
  assign mode_w        = conceal_e'(conceal_mode_i);

  sf_hold_bank #(.AUDIO_W(AUDIO_W), .CH_N(CH_N)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (good_accept_w),
    .wr_ch  (chan_w),
    .wr_data(audio_w),
    .rd_ch  (chan_w),
    .rd_data(held_w)
  );

  sf_err_tally #(.CNT_W(CNT_W)) u_tally (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (err_clr_i),
    .bump (bad_accept_w),
    .cnt  (err_cnt_o)
  );

  always_comb begin
    if (!parity_bad_w) begin
      next_sample_w = audio_w;
    end else begin
      unique case (mode_w)
        CONCEAL_HOLD: next_sample_w = held_w;
        CONCEAL_PASS: next_sample_w = audio_w;
        default:      next_sample_w = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_vld_o <= 1'b0;
      sample_o     <= '0;
      chan_right_o <= 1'b0;
      flags_o      <= '0;
    end else begin
      sample_vld_o <= word_vld_i;
      if (word_vld_i) begin
        sample_o     <= next_sample_w;
        chan_right_o <= chan_w;
        flags_o      <= flags_w;
      end
    end
  end
endmodule

// File: rtl/sf_guard_checker.sv
module sf_guard_checker #(
  parameter int WORD_W  = 32,
  parameter int AUDIO_W = 24,
  parameter int FLAG_W  = 4,
  parameter int CNT_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [WORD_W-1:0]  word_i,
  input logic               word_vld_i,
  input logic [1:0]         conceal_mode_i,
  input logic               err_clr_i,
  input logic               parity_bad_w,
  input logic [AUDIO_W-1:0] sample_o,
  input logic               sample_vld_o,
  input logic [FLAG_W-1:0]  flags_o,
  input logic [CNT_W-1:0]   err_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  assert_strobe_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_i |=> sample_vld_o);
  assert_no_spurious_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld_i |=> !sample_vld_o);
  assert_good_passes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld_i && !parity_bad_w) |=> sample_o == $past(word_i[AUDIO_W+3:4]));
  assert_mute_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld_i && parity_bad_w && (conceal_mode_i == 2'b00 || conceal_mode_i == 2'b11))
    |=> sample_o == '0);
  assert_pass_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld_i && conceal_mode_i == 2'b10) |=> sample_o == $past(word_i[AUDIO_W+3:4]));
  assert_flags_raw_R10: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_i |=> flags_o == $past(word_i[WORD_W-1:WORD_W-FLAG_W]));
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld_i && parity_bad_w && !err_clr_i && err_cnt_o != CNT_MAX)
    |=> err_cnt_o == $past(err_cnt_o) + CNT_ONE);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt_o == CNT_MAX && !err_clr_i) |=> err_cnt_o == CNT_MAX);
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr_i |=> err_cnt_o == '0);
endmodule

bind spdif_frame_guard sf_guard_checker #(
  .WORD_W(WORD_W), .AUDIO_W(AUDIO_W), .FLAG_W(FLAG_W), .CNT_W(CNT_W)
) u_guard_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .word_i        (word_i),
  .word_vld_i    (word_vld_i),
  .conceal_mode_i(conceal_mode_i),
  .err_clr_i     (err_clr_i),
  .parity_bad_w  (parity_bad_w),
  .sample_o      (sample_o),
  .sample_vld_o  (sample_vld_o),
  .flags_o       (flags_o),
  .err_cnt_o     (err_cnt_o)
);

// File: tb/test_spdif_frame_guard.sv
module test_spdif_frame_guard;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic [23:0] smp;
    logic        right;
    logic [3:0]  flg;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] word_i = '0;
  logic [1:0]  sync_kind_i = '0;
  logic        word_vld_i = 1'b0;
  logic [1:0]  conceal_mode_i = '0;
  logic        err_clr_i = 1'b0;
  logic [23:0] sample_o;
  logic        chan_right_o;
  logic [3:0]  flags_o;
  logic        sample_vld_o;
  logic [15:0] err_cnt_o;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t sb_q[$];
  logic [23:0] held [2];
  int   exp_errs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spdif_frame_guard i_spdif_frame_guard (
    .clk(clk), .rst_n(rst_n), .word_i(word_i), .sync_kind_i(sync_kind_i),
    .word_vld_i(word_vld_i), .conceal_mode_i(conceal_mode_i), .err_clr_i(err_clr_i),
    .sample_o(sample_o), .chan_right_o(chan_right_o), .flags_o(flags_o),
    .sample_vld_o(sample_vld_o), .err_cnt_o(err_cnt_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: builds one subframe, predicts the result, pushes it.
  task automatic send(input logic [23:0] aud, input logic [2:0] fl, input logic right,
                      input logic corrupt, input logic [1:0] mode);
    logic [31:0] w;
    logic [23:0] rx;
    exp_t e;
    w[3:0]   = 4'($urandom);
    w[27:4]  = aud;
    w[30:28] = fl;
    w[31]    = ^{fl, aud};
    if (corrupt) w[27] = ~w[27];
    rx = w[27:4];
    if (!corrupt) begin
      e.smp = rx;
      held[right] = rx;
    end else begin
      case (mode)
        2'b01:   e.smp = held[right];
        2'b10:   e.smp = rx;
        default: e.smp = '0;
      endcase
      if (exp_errs < 65535) exp_errs++;
    end
    e.right = right;
    e.flg   = w[31:28];
    sb_q.push_back(e);
    word_i         = w;
    sync_kind_i    = right ? 2'b10 : ((w[0]) ? 2'b11 : 2'b01);
    conceal_mode_i = mode;
    word_vld_i     = 1'b1;
    @(negedge clk);
  endtask

  task automatic gap();
    word_vld_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!sample_vld_o, "R3 idle strobe", sample_vld_o, 0);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && sample_vld_o) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R3 unexpected strobe", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(sample_o == e.smp, "R2/R5/R6/R7 sample", sample_o, e.smp);
        chk(chan_right_o == e.right, "R4 channel", chan_right_o, e.right);
        chk(flags_o == e.flg, "R10 flags", flags_o, e.flg);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    held[0] = '0;
    held[1] = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(sample_o == 0 && flags_o == 0 && !chan_right_o && !sample_vld_o && err_cnt_o == 0,
        "R11 reset outputs", {sample_o, flags_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: hold before any good sample gives zero on both channels
    send(24'h000123, 3'b001, 1'b0, 1'b1, 2'b01);
    send(24'h000456, 3'b010, 1'b1, 1'b1, 2'b01);
    gap();

    // R1, R2, R12: good frames with random sync nibble and data
    for (int i = 0; i < 20; i++)
      send(24'($urandom), 3'($urandom), 1'(i % 2), 1'b0, 2'($urandom));
    gap();

    // R5: mute, both codes; MSB flip of small positive
    send(24'h000400, 3'b000, 1'b0, 1'b1, 2'b00);
    send(24'h000401, 3'b100, 1'b1, 1'b1, 2'b11);
    // R7: pass shows the negative spike
    send(24'h001000, 3'b011, 1'b0, 1'b1, 2'b10);
    gap();

    // R6: per-channel hold with interleaving
    send(24'h111111, 3'b000, 1'b0, 1'b0, 2'b01);
    send(24'h222222, 3'b000, 1'b1, 1'b0, 2'b01);
    send(24'h000333, 3'b101, 1'b0, 1'b1, 2'b01);
    send(24'h000444, 3'b110, 1'b1, 1'b1, 2'b01);
    send(24'h333333, 3'b000, 1'b1, 1'b0, 2'b01);
    send(24'h000555, 3'b111, 1'b0, 1'b1, 2'b01);
    send(24'h000666, 3'b111, 1'b1, 1'b1, 2'b01);
    gap();

    // R8: count so far
    chk(err_cnt_o == 16'(exp_errs), "R8 count", err_cnt_o, exp_errs);

    // R9: clear with a simultaneous failure
    err_clr_i = 1'b1;
    send(24'h000777, 3'b000, 1'b0, 1'b1, 2'b00);
    err_clr_i = 1'b0;
    exp_errs = 0;
    chk(err_cnt_o == 0, "R9 clear wins", err_cnt_o, 0);
    gap();

    // R8: saturation under a long burst
    for (int i = 0; i < 65540; i++)
      send(24'h000010, 3'b000, 1'(i % 2), 1'b1, 2'b00);
    gap();
    chk(err_cnt_o == 16'hFFFF, "R8 saturate", err_cnt_o, 16'hFFFF);
    send(24'h000010, 3'b000, 1'b0, 1'b1, 2'b10);
    gap();
    chk(err_cnt_o == 16'hFFFF, "R8 stays saturated", err_cnt_o, 16'hFFFF);
    chk(sb_q.size() == 0, "R3 all strobes seen", sb_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule